// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write single bytes in an external asynchronous static RAM. The RAM holds 512K bytes, uses active-low chip enable, output enable and write enable strobes, and shares one 8-bit bus for data in and data out. The host offers a request with a valid/ready handshake. The controller registers the address and the write data. It then moves through a fixed strobe sequence that is counted in clock cycles, so the RAM's access, write-pulse and bus-release times are met at the chosen clock period.

Every strobe and the bus drive enable come straight from flops. No strobe is decoded combinationally at the pins, so none can glitch. The address is set one cycle before chip enable falls and is held until the next request. Write data goes onto the bus one cycle before write enable falls and stays there one cycle after it rises. After a read, a turnaround gap lets the RAM release the bus before the controller can drive it again. Three parameters set the wait-state counts: `READ_WAIT`, `WE_WAIT` and `TURN_WAIT`.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, req_ready is 1, busy is 0, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and rd_valid is 0.
- R2: req_ready is 1 only when the controller is idle, and then all three strobes are inactive (1). A request is taken only on a clock edge where req_valid and req_ready are both 1. A req_valid raised while req_ready is 0 is ignored and writes nothing to memory.
- R3: mem_addr takes req_addr on the accepting edge. It is on the bus at least one cycle before mem_ce_n falls and does not change while mem_ce_n is 0.
- R4: A read (req_write = 0) holds mem_ce_n = 0, mem_oe_n = 0 and mem_we_n = 1 for exactly READ_WAIT cycles.
- R5: rd_data takes mem_dq_in on the edge that ends the read window. rd_valid is 1 for exactly one cycle, starting READ_WAIT+1 clock edges after the accepting edge.
- R6: A write (req_write = 1) holds mem_ce_n = 0 and mem_we_n = 0 for exactly WE_WAIT cycles while mem_oe_n stays 1. mem_dq_oe is 1 from one cycle before mem_we_n falls until one cycle after it rises. mem_dq_out then carries the accepted req_wdata, so a later read of that address returns it.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0.
- R8: After a read, req_ready returns READ_WAIT+TURN_WAIT+1 edges after the accepting edge. mem_dq_oe cannot rise until more than TURN_WAIT cycles after mem_oe_n has risen. After a write, req_ready returns WE_WAIT+2 edges after the accepting edge.
- R9: busy is always the inverse of req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| busy | output | 1 | A transfer is in progress |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse, rd_data is fresh |
| mem_addr | output | 19 | RAM address bus |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data to the RAM bus pads |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the RAM bus pads |

## Verification
The bench's RAM model returns a poison byte until output enable has been low for READ_WAIT cycles. A controller that samples early therefore reads wrong data and fails the scoreboard. The bench runs a read straight after a write and a write straight after a read. A design that drops the data hold cycle or the turnaround gap either drives against the RAM's output or has its write pulse measured too short. Requests offered while the controller is busy must leave memory unchanged, which a later readback of that address shows. Latency checks from the accepting edge catch any off-by-one in the wait counters.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ_WAIT,
    ST_WRITE_PULSE,
    ST_WRITE_RECOVER,
    ST_TURNAROUND
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // bits needed to hold a wait count of n cycles (count runs n-1 .. 0)
  function automatic int cnt_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // reload value for a state that must last 'cycles' clocks
  function automatic int wait_reload(input int cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

  function automatic logic is_timed(input ctrl_state_e st);
    return (st == ST_READ_WAIT) || (st == ST_WRITE_PULSE) || (st == ST_TURNAROUND);
  endfunction

  // pin levels that belong to a state; registered one edge ahead
  function automatic strobes_t strobes_for(input ctrl_state_e st, input logic wr);
    strobes_t s;
    s = STROBES_IDLE;
    case (st)
      ST_SETUP:         s.dq_oe = wr;
      ST_READ_WAIT:     begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      ST_WRITE_PULSE:   begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
      ST_WRITE_RECOVER: s.dq_oe = 1'b1;
      default:          s = STROBES_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int READ_WAIT = 4,
  parameter int WE_WAIT   = 3,
  parameter int TURN_WAIT = 1,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             wait_done,
  output logic             accept,
  output logic             capture,
  output logic             wr_d,
  output ctrl_state_e      state_q,
  output ctrl_state_e      state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  logic wr_q;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_READ_WAIT) && wait_done;
  assign wr_d    = accept ? req_write : wr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:          if (accept) state_d = ST_SETUP;
      ST_SETUP:         state_d = wr_q ? ST_WRITE_PULSE : ST_READ_WAIT;
      ST_READ_WAIT:     if (wait_done) state_d = ST_TURNAROUND;
      ST_WRITE_PULSE:   if (wait_done) state_d = ST_WRITE_RECOVER;
      ST_WRITE_RECOVER: state_d = ST_IDLE;
      ST_TURNAROUND:    if (wait_done) state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load     = (state_d != state_q) && is_timed(state_d);
    load_val = '0;
    case (state_d)
      ST_READ_WAIT:   load_val = CNT_W'(wait_reload(READ_WAIT));
      ST_WRITE_PULSE: load_val = CNT_W'(wait_reload(WE_WAIT));
      ST_TURNAROUND:  load_val = CNT_W'(wait_reload(TURN_WAIT));
      default:        load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
    end
  end

endmodule

// File: rtl/asram_bus.sv
module asram_bus
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  ctrl_state_e       state_d,
  input  logic              wr_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  strobes_t strb_q;
  strobes_t strb_d;

  assign strb_d = strobes_for(state_d, wr_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q     <= STROBES_IDLE;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      strb_q   <= strb_d;
      rd_valid <= capture;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rd_data <= mem_dq_in;
    end
  end

  assign mem_ce_n  = strb_q.ce_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_dq_oe = strb_q.dq_oe;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int READ_WAIT = 4,
  parameter int WE_WAIT   = 3,
  parameter int TURN_WAIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CNT_W = cnt_bits(max3(READ_WAIT, WE_WAIT, TURN_WAIT));

  generate
    if (READ_WAIT < 1 || WE_WAIT < 1 || TURN_WAIT < 1) begin : g_bad_wait
      $error("asram_ctrl: every wait count must be at least one cycle");
    end
  endgenerate

  // named internal events, also seen by the bound checker
  logic             accept;
  logic             capture;
  logic             wr_d;
  logic             wait_done;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  ctrl_state_e      state_q;
  ctrl_state_e      state_d;

  asram_seq #(
    .READ_WAIT(READ_WAIT),
    .WE_WAIT  (WE_WAIT),
    .TURN_WAIT(TURN_WAIT),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .wait_done(wait_done),
    .accept   (accept),
    .capture  (capture),
    .wr_d     (wr_d),
    .state_q  (state_q),
    .state_d  (state_d),
    .load     (cnt_load),
    .load_val (cnt_load_val)
  );

  asram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_load_val),
    .done    (wait_done)
  );

  asram_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .state_d   (state_d),
    .wr_d      (wr_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W    = 19,
  parameter int READ_WAIT = 4,
  parameter int WE_WAIT   = 3,
  parameter int TURN_WAIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_low_cnt;
  logic [15:0] oe_low_cnt;
  logic [15:0] oe_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
      oe_gap     <= '1;
    end else begin
      we_low_cnt <= !mem_we_n ? ((we_low_cnt != '1) ? we_low_cnt + 1'b1 : we_low_cnt) : '0;
      oe_low_cnt <= !mem_oe_n ? ((oe_low_cnt != '1) ? oe_low_cnt + 1'b1 : oe_low_cnt) : '0;
      if (!mem_oe_n)         oe_gap <= '0;
      else if (oe_gap != '1) oe_gap <= oe_gap + 1'b1;
    end
  end

  AST_READY_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n)); // R2
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2
  AST_ADDR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $stable(mem_addr)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_cnt == 16'(READ_WAIT))); // R4
  AST_RD_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5
  AST_RD_VALID_AT_OE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $rose(mem_oe_n)); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(WE_WAIT))); // R6
  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R6
  AST_DQ_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe)); // R6
  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (oe_gap > 16'(TURN_WAIT))); // R8

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .READ_WAIT(READ_WAIT),
  .WE_WAIT  (WE_WAIT),
  .TURN_WAIT(TURN_WAIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int RW = 4;
  localparam int WW = 3;
  localparam int TW = 1;
  localparam int MD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, busy, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .READ_WAIT(RW), .WE_WAIT(WW), .TURN_WAIT(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #2 clk = ~clk;  // 250 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- RAM model (updated mid-cycle) ----------------
  logic [DW-1:0] mem_m [0:MD-1];
  logic [DW-1:0] shadow [0:MD-1];
  int            ocnt = 0;
  int            wcnt = 0;
  bit            wr_seen = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  bit            ce_was_low = 1'b0;
  logic [AW-1:0] ce_addr = '0;
  logic          rd_en;

  assign rd_en     = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (rd_en && ocnt >= RW) ? mem_m[mem_addr[9:0]] : 8'hEE;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MD; i++) mem_m[i] <= '0;
      ocnt <= 0; wcnt <= 0; wr_seen <= 1'b0; ce_was_low <= 1'b0;
    end else begin
      if (rd_en) ocnt <= ocnt + 1;
      else begin
        if (ocnt != 0) chk(ocnt == RW, "R4 read window length", ocnt, RW);
        ocnt <= 0;
      end
      if (!mem_ce_n && !mem_we_n) begin
        wcnt <= wcnt + 1; wr_seen <= 1'b1;
        wr_addr <= mem_addr; wr_data <= mem_dq_out;
        chk(mem_dq_oe, "R6 drive during pulse", mem_dq_oe, 1);
        chk(mem_oe_n, "R6 oe_n high during write", mem_oe_n, 1);
      end else if (wr_seen) begin
        mem_m[wr_addr[9:0]] <= wr_data;
        chk(wcnt == WW, "R6 write pulse length", wcnt, WW);
        chk(mem_dq_oe, "R6 data hold cycle", mem_dq_oe, 1);
        wcnt <= 0; wr_seen <= 1'b0;
      end
      if (mem_dq_oe) chk(mem_oe_n, "R7 no drive with oe_n low", mem_oe_n, 1);
      if (!mem_ce_n && ce_was_low) chk(mem_addr == ce_addr, "R3 address stable", mem_addr, ce_addr);
      ce_was_low <= !mem_ce_n;
      ce_addr    <= mem_addr;
      chk(busy == !req_ready, "R9 busy inverse", busy, !req_ready);
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [DW-1:0] d;
    logic [31:0]   c;
  } exp_t;
  exp_t exp_q[$];
  bit   rv_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rv_prev) chk(!rd_valid, "R5 rd_valid single cycle", rd_valid, 0);
      if (rd_valid && !rv_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected rd_valid", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rd_data == e.d, "R5 read data", rd_data, e.d);
          chk(cyc - e.c == RW + 2, "R5 rd_valid latency", cyc - e.c, RW + 2);
        end
      end
      rv_prev <= rd_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit noise);
    int unsigned acc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    acc = cyc;
    if (wr) shadow[a[9:0]] = d;
    else exp_q.push_back('{d: shadow[a[9:0]], c: acc});
    @(negedge clk);
    chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
    if (noise) begin
      // offered while busy: must be ignored
      req_write = 1'b1; req_addr = a ^ 19'h00155; req_wdata = 8'h77;
      @(negedge clk);
      chk(!req_ready, "R2 still busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    if (wr) chk(cyc - acc == WW + 3, "R8 write ready latency", cyc - acc, WW + 3);
    else    chk(cyc - acc == RW + TW + 2, "R8 read ready latency", cyc - acc, RW + TW + 2);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R2 strobes off when ready",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
  endtask

  initial begin
    for (int i = 0; i < MD; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !rd_valid, "R1 reset handshake", {req_ready, busy, rd_valid}, 3'b100);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 reset strobes",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && mem_ce_n && !mem_dq_oe, "R1 after reset",
        {req_ready, busy, mem_ce_n, mem_dq_oe}, 4'b1010);

    // R6 R5: write patterns and read them back, boundary addresses included
    issue(1'b1, 19'h00000, 8'hA5, 1'b0);
    issue(1'b1, 19'h7FFFF, 8'h5A, 1'b0);
    issue(1'b1, 19'h00001, 8'hFF, 1'b0);
    issue(1'b1, 19'h00002, 8'h00, 1'b0);
    issue(1'b0, 19'h00000, 8'h00, 1'b0);
    issue(1'b0, 19'h7FFFF, 8'h00, 1'b0);
    issue(1'b0, 19'h00001, 8'h00, 1'b0);
    issue(1'b0, 19'h00002, 8'h00, 1'b0);

    // R2: request offered during a busy write is ignored
    issue(1'b1, 19'h00010, 8'h3C, 1'b1);
    issue(1'b0, 19'h00010 ^ 19'h00155, 8'h00, 1'b0);
    issue(1'b0, 19'h00010, 8'h00, 1'b0);

    // R7 R8: write right after read, read right after write, overwrite
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] a;
      a = AW'((k * 37 + 5) % 600);
      issue(1'b1, a, DW'(k * 29 + 11), 1'b0);
      issue(1'b0, a, 8'h00, 1'b0);
      issue(1'b1, a, DW'(~(k * 13)), 1'b0);
      issue(1'b0, a, 8'h00, 1'b0);
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule